// File: doc/BRIEF.md
# Self-Halting Galois Shift-Register Pattern Generator

This block holds a wide linear-feedback shift register that begins stepping from a fixed seed as soon as synchronous reset is released. Nothing drives it except the clock. Each cycle it advances one Galois step, shifting toward the least significant bit and folding the old LSB back in at the tap positions. It keeps going until the low-order slice of the register equals a fixed stop constant. From then on the register freezes, so downstream logic sees a stable wide pattern. Downstream comparators use that pattern whole, or as its lower and upper halves.

With the default parameters the register is 128 bits wide. The stop constant is the seven ASCII bytes `CTF-BR{`, with `C` in byte 0. The defaults bring the register to rest on a sixteen-character printable string. The seed, the tap mask, the stop slice width and the stop value are all parameters.

Control is a two-state machine:
- STEP: the register advances every cycle.
- HELD: the register is frozen.

Its transitions are:
- CATCH: STEP to HELD, taken when the value being loaded has a matching low slice.
- RELOAD: reset from either state. It lands in HELD when the seed itself matches, and in STEP otherwise.

Top module: `lfsr_prefix_stop`

## Requirements
- R1: While `rst` is high at a rising edge, the register loads SEED. The settled flag then equals whether SEED's low MATCH_BITS bits equal MATCH_VAL.
- R2: When the register steps, every bit i below the top takes old bit i+1 XOR (TAPS[i] AND old bit 0). The top bit takes TAPS[WIDTH-1] AND old bit 0. With the default mask 0xe1 followed by 30 zero nibbles, the old LSB enters bits 127, 126, 125 and 120.
- R3: The register steps on a rising edge only while its low MATCH_BITS bits differ from MATCH_VAL. The default stop value is 0x7b52422d465443, which is the bytes 43,54,46,2d,42,52,7b placed in bytes 0 to 6.
- R4: Once the low slice matches, the register holds its value on every later cycle until reset.
- R5: `settled_o` is a registered flag. It is high exactly when the register is held (state HELD) and low while it steps (state STEP).
- R6: `lo_half_o` equals register bits [WIDTH/2-1:0], and `hi_half_o` equals bits [WIDTH-1:WIDTH/2].
- R7: With the default tap mask and stop constant, a register seeded K steps before 0x7d4e586625642e31477b52422d465443 stops on that value after exactly K steps. That value is the ASCII text `CTF-BR{G1.d%fXN}` read little-endian.
- R8: Reset applied while the register is HELD reloads SEED, and stepping resumes from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, reloads the seed |
| state_o | output | WIDTH | Full register value |
| settled_o | output | 1 | High once the register has stopped |
| lo_half_o | output | WIDTH/2 | Lower half of the register |
| hi_half_o | output | WIDTH/2 | Upper half of the register |

## Verification
The bench builds eight 16-bit copies with tap mask 0xB400 and an 8-bit stop value of 0x5A, each from a different seed. One seed already matches at reset. With an 8-bit stop slice, every copy halts within a few hundred steps, so the whole walk from seed to halt can be followed cycle by cycle, including the first cycle of the hold and the cycles after it. A 128-bit copy with the default taps and stop constant is seeded by stepping the final string backwards 24 times. This brings the full-width halt on the ASCII string within a short run, which a run from the default seed would not.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
    typedef enum logic {
        ST_STEP = 1'b0,
        ST_HELD = 1'b1
    } lfsr_state_e;
endpackage

// File: rtl/lfsr_next.sv
module lfsr_next #(
    parameter int                 WIDTH = 128,
    parameter logic [WIDTH-1:0]   TAPS  = {8'he1, {(WIDTH-8){1'b0}}}
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);
    // One Galois step toward the LSB; old LSB folded in at tap bits.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == WIDTH - 1) begin : g_top
            assign nxt[i] = TAPS[i] & cur[0];
        end else begin : g_mid
            assign nxt[i] = cur[i+1] ^ (TAPS[i] & cur[0]);
        end
    end
endmodule

// File: rtl/prefix_cmp.sv
module prefix_cmp #(
    parameter int                    WIDTH      = 128,
    parameter int                    MATCH_BITS = 56,
    parameter logic [MATCH_BITS-1:0] MATCH_VAL  = 56'h7b52422d465443
) (
    input  logic [WIDTH-1:0] value,
    output logic             hit
);
    logic [MATCH_BITS-1:0] slice;
    logic [WIDTH-MATCH_BITS-1:0] unused_upper;

    assign slice        = value[MATCH_BITS-1:0];
    assign unused_upper = value[WIDTH-1:MATCH_BITS];
    assign hit          = (slice == MATCH_VAL);
endmodule

// File: rtl/lfsr_ctrl.sv
module lfsr_ctrl
    import lfsr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic seed_hit,
    input  logic next_hit,
    output logic advance,
    output logic settled
);
    lfsr_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = seed_hit ? ST_HELD : ST_STEP;     // RELOAD
        end else begin
            unique case (st_q)
                ST_STEP: if (next_hit) st_d = ST_HELD; // CATCH
                ST_HELD: st_d = ST_HELD;
                default: st_d = ST_STEP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            ST_STEP: begin advance = 1'b1; settled = 1'b0; end
            ST_HELD: begin advance = 1'b0; settled = 1'b1; end
            default: begin advance = 1'b0; settled = 1'b0; end
        endcase
    end

    // R4: HELD is left only through reset
    p_held_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        settled |=> settled);
endmodule

// File: rtl/lfsr_prefix_stop.sv
module lfsr_prefix_stop #(
    parameter int                    WIDTH      = 128,
    parameter logic [WIDTH-1:0]      TAPS       = 128'he1000000000000000000000000000000,
    parameter logic [WIDTH-1:0]      SEED       = 128'h5adf01e748ef22e547ce8210c60e48ff,
    parameter int                    MATCH_BITS = 56,
    parameter logic [MATCH_BITS-1:0] MATCH_VAL  = 56'h7b52422d465443
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic [WIDTH-1:0]     state_o,
    output logic                 settled_o,
    output logic [WIDTH/2-1:0]   lo_half_o,
    output logic [WIDTH/2-1:0]   hi_half_o
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] reg_q;
    logic [WIDTH-1:0] step_val;
    logic             seed_hit, next_hit, advance, settled;

    lfsr_next #(.WIDTH(WIDTH), .TAPS(TAPS)) u_next (
        .cur (reg_q),
        .nxt (step_val)
    );

    prefix_cmp #(.WIDTH(WIDTH), .MATCH_BITS(MATCH_BITS), .MATCH_VAL(MATCH_VAL)) u_cmp_seed (
        .value (SEED),
        .hit   (seed_hit)
    );

    prefix_cmp #(.WIDTH(WIDTH), .MATCH_BITS(MATCH_BITS), .MATCH_VAL(MATCH_VAL)) u_cmp_next (
        .value (step_val),
        .hit   (next_hit)
    );

    lfsr_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .seed_hit (seed_hit),
        .next_hit (next_hit),
        .advance  (advance),
        .settled  (settled)
    );

    always_ff @(posedge clk) begin
        if (rst)          reg_q <= SEED;
        else if (advance) reg_q <= step_val;
    end

    assign state_o   = reg_q;
    assign settled_o = settled;
    assign lo_half_o = reg_q[HALF-1:0];
    assign hi_half_o = reg_q[WIDTH-1:HALF];

    // R1: reset reloads the seed
    p_seed_load_r1: assert property (@(posedge clk)
        rst |=> reg_q == SEED);
    // R4: frozen while settled
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        settled |=> $stable(reg_q));
    // R3: a stepping nonzero register always changes
    p_moves_r3: assert property (@(posedge clk) disable iff (rst)
        (!settled && reg_q != '0) |=> reg_q != $past(reg_q));
    // R2: top bit receives the old LSB through its tap
    p_top_feed_r2: assert property (@(posedge clk) disable iff (rst)
        !settled |=> reg_q[WIDTH-1] == (TAPS[WIDTH-1] & $past(reg_q[0])));
    // R5: flag agrees with the low slice of the register
    p_flag_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> settled == (reg_q[MATCH_BITS-1:0] == MATCH_VAL));
endmodule

// File: tb/test_lfsr_prefix_stop.sv
module test_lfsr_prefix_stop;
    localparam int              NS     = 8;
    localparam logic [15:0]     TAPS16 = 16'hB400;
    localparam logic [7:0]      STOP16 = 8'h5A;
    localparam logic [127:0]    TAPSB  = 128'he1000000000000000000000000000000;
    localparam logic [127:0]    FINAL  = 128'h7d4e586625642e31477b52422d465443;
    localparam logic [55:0]     STOPB  = 56'h7b52422d465443;
    localparam int              KBACK  = 24;

    function automatic logic [15:0] seed_of(input int g);
        if (g == 0) return 16'hC35A;
        return 16'(g * 16'h2B1D + 16'h0101);
    endfunction

    function automatic logic [127:0] back128(input logic [127:0] v, input int k);
        logic [127:0] t;
        t = v;
        for (int i = 0; i < k; i++) begin
            logic l;
            l = t[127];
            t = t ^ (l ? TAPSB : 128'h0);
            t = {t[126:0], l};
        end
        return t;
    endfunction

    localparam logic [127:0] SEEDB = back128(FINAL, KBACK);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [15:0] s_st  [NS];
    logic        s_set [NS];
    logic [7:0]  s_lo  [NS];
    logic [7:0]  s_hi  [NS];

    for (genvar g = 0; g < NS; g++) begin : g_small
        lfsr_prefix_stop #(.WIDTH(16), .TAPS(TAPS16), .SEED(seed_of(g)),
                           .MATCH_BITS(8), .MATCH_VAL(STOP16)) i_lfsr_prefix_stop (
            .clk(clk), .rst(rst), .state_o(s_st[g]), .settled_o(s_set[g]),
            .lo_half_o(s_lo[g]), .hi_half_o(s_hi[g]));
    end

    logic [127:0] b_st;
    logic         b_set;
    logic [63:0]  b_lo, b_hi;

    lfsr_prefix_stop #(.SEED(SEEDB)) i_lfsr_prefix_stop (
        .clk(clk), .rst(rst), .state_o(b_st), .settled_o(b_set),
        .lo_half_o(b_lo), .hi_half_o(b_hi));

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    int steps   = 0;
    bit done    = 0;

    logic [15:0]  m_st  [NS];
    bit           m_set [NS];
    logic [127:0] mb_st;
    bit           mb_set;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    // Model update for one rising edge, using rst as held at that edge (R1, R2, R3, R8)
    task automatic model_edge();
        for (int g = 0; g < NS; g++) begin
            if (rst) begin
                m_st[g]  = seed_of(g);
                m_set[g] = (m_st[g][7:0] == STOP16);
            end else if (!m_set[g]) begin
                m_st[g]  = (m_st[g] >> 1) ^ (m_st[g][0] ? TAPS16 : 16'h0);
                m_set[g] = (m_st[g][7:0] == STOP16);
            end
        end
        if (rst) begin
            mb_st  = SEEDB;
            mb_set = (SEEDB[55:0] == STOPB);
        end else if (!mb_set) begin
            mb_st  = (mb_st >> 1) ^ (mb_st[0] ? TAPSB : 128'h0);
            mb_set = (mb_st[55:0] == STOPB);
        end
    endtask

    task automatic compare_all(input string tag);
        for (int g = 0; g < NS; g++) begin
            chk({tag, " R2 R3 R4 small state"}, 128'(s_st[g]), 128'(m_st[g]));
            chk({tag, " R5 small settled"}, 128'(s_set[g]), 128'(m_set[g]));
            chk("R6 small lo", 128'(s_lo[g]), 128'(m_st[g][7:0]));
            chk("R6 small hi", 128'(s_hi[g]), 128'(m_st[g][15:8]));
        end
        chk({tag, " R7 wide state"}, b_st, mb_st);
        chk({tag, " R5 wide settled"}, 128'(b_set), 128'(mb_set));
        chk("R6 wide lo", 128'(b_lo), 128'(mb_st[63:0]));
        chk("R6 wide hi", 128'(b_hi), 128'(mb_st[127:64]));
    endtask

    task automatic cycle(input string tag);
        @(posedge clk);
        model_edge();
        cyc++;
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        for (int g = 0; g < NS; g++) begin m_st[g] = '0; m_set[g] = 0; end
        mb_st = '0; mb_set = 0;
        rst = 1'b1;
        cycle("R1");
        cycle("R1");
        chk("R1 seed held-at-reset copy settled", 128'(s_set[0]), 128'd1);
        chk("R1 wide seed", b_st, SEEDB);
        rst = 1'b0;
        // stepping phase: run until every model has settled
        for (int n = 0; n < 20000; n++) begin
            bit all_set;
            cycle("R3");
            steps++;
            if (b_set && steps == KBACK) chk("R7 wide step count", 128'(steps), 128'(KBACK));
            if (steps == KBACK) chk("R7 wide final string", b_st, FINAL);
            all_set = mb_set;
            for (int g = 0; g < NS; g++) all_set &= m_set[g];
            if (all_set) break;
        end
        // hold phase: more than 1000 further cycles without change
        for (int n = 0; n < 1100; n++) cycle("R4");
        chk("R4 wide still final", b_st, FINAL);
        // reset while held
        rst = 1'b1;
        cycle("R8");
        rst = 1'b0;
        chk("R8 wide reloaded", b_st, SEEDB);
        chk("R8 wide flag cleared", 128'(b_set), 128'd0);
        for (int n = 0; n < 400; n++) cycle("R8");
        chk("R8 wide final again", b_st, FINAL);
        finish_up();
    end

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
        finish_up();
    end
endmodule